// File: doc/BRIEF.md
# SD Card Data Path Sequencer

This block is the data-phase controller of an SD/MMC-style host. Software or a command engine programs a byte count, a data timeout and an acknowledge timeout. It then issues a one-cycle start with a direction bit. The sequencer walks the transfer through its phases. On receive, it waits for the first data byte and then counts the rest. On send, it pushes bytes and may then wait out the card's busy signal and an acknowledge from the card. The serializer reports each finished byte with a one-cycle strobe.

Two independent down-counters watch the phases in which the card might never answer. The data timer covers waiting for receive data and the card-busy phase. The acknowledge timer covers waiting for the acknowledge. Both timers advance only on a card-clock enable strobe. A transfer ends with exactly one single-cycle event: data end, data timeout or acknowledge timeout. Data end is withheld when an error was reported during the transfer.

Top module: `sd_data_seq`

## Requirements
- R1: A start pulse in Idle moves the state to Wait-receive (code 5) when `dir_send`=0, or to Wait-send (code 1) when `dir_send`=1. On that same edge, `remaining_o` loads `len_in`.
- R2: In Wait-receive (5), Receive (6), Wait-send (1) and Send (2), each `byte_stb` with a nonzero `remaining_o` lowers `remaining_o` by one. A byte in Wait-receive moves the state to Receive, and a byte in Wait-send moves it to Send.
- R3: In Receive with `remaining_o`=0, the next edge returns the state to Idle (0) and raises `data_end_o` for one cycle.
- R4: When `err_in` is high in any cycle while the state is not Idle, the transfer ends without `data_end_o`.
- R5: The data timer loads `data_tmo_in` on each entry into Wait-receive or Busy (3). It counts only `card_ce` strobes spent in that state. On the max(T,1)-th such strobe, the next edge returns to Idle with a one-cycle `data_tmo_o`. A byte arriving in Wait-receive, or busy falling in Busy, in that same cycle takes priority.
- R6: The acknowledge timer loads `ack_tmo_in` on each entry into Wait-ack (4) and counts `card_ce` strobes there. On the max(T,1)-th strobe, the next edge returns to Idle with a one-cycle `ack_tmo_o`.
- R7: In Send with `remaining_o`=0, the next state is chosen in this order: Busy if `busy_in` is high, otherwise Wait-ack if `ack_en` is high, otherwise Idle with `data_end_o`. When `busy_in` falls in Busy, the next state is Wait-ack if `ack_en` is high, otherwise Idle with `data_end_o`.
- R8: `ack_rcvd` in Wait-ack returns the state to Idle with `data_end_o` on the next edge.
- R9: With `len_in`=0, the state leaves Idle and returns to Idle on the next edge, raising `data_end_o` in either direction.
- R10: A start pulse outside Idle changes neither the state nor `remaining_o`.
- R11: At most one of the three event outputs is high in any cycle. Each one is high for a single cycle, and only while the state is Idle.
- R12: After reset, the state is Idle, `remaining_o` is 0 and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_ce | input | 1 | One-cycle strobe per card bus clock period |
| start | input | 1 | Begin a transfer (honoured in Idle only) |
| dir_send | input | 1 | 1 = send to card, 0 = receive from card |
| len_in | input | LEN_W | Number of bytes to move |
| data_tmo_in | input | TMO_W | Data timeout in card clock periods |
| ack_tmo_in | input | TMO_W | Acknowledge timeout in card clock periods |
| byte_stb | input | 1 | One byte finished on the line |
| busy_in | input | 1 | Card holds the data line busy |
| ack_en | input | 1 | This send expects an acknowledge |
| ack_rcvd | input | 1 | Acknowledge received from the card |
| err_in | input | 1 | Error reported by the line logic (CRC and similar) |
| state_o | output | 3 | Current phase code |
| remaining_o | output | LEN_W | Bytes still to move |
| data_end_o | output | 1 | Transfer finished without error |
| data_tmo_o | output | 1 | Data timeout event |
| ack_tmo_o | output | 1 | Acknowledge timeout event |

## Verification
The hardest case to reach from the ports is a timeout in the Busy phase. To get there, a send must finish its last byte with `busy_in` already high. The bench must then hold busy while it feeds a random pattern of `card_ce` strobes. Strobes issued during Wait-send and Send must not advance the timer, so the bench keeps the enable high through those phases as well. The expected expiry point is counted only from strobes the bench issues after it sees state code 3. Receive timeouts use the same strobe counting against random timeout values, including zero. Back-to-back runs confirm that the timer reloads on every entry.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSEND  = 3'd1,
        ST_SEND   = 3'd2,
        ST_BUSY   = 3'd3,
        ST_WACK   = 3'd4,
        ST_WRECV  = 3'd5,
        ST_RECV   = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic data_end;
        logic data_tmo;
        logic ack_tmo;
    } seq_events_t;

    function automatic logic data_timed(input seq_state_e s);
        return (s == ST_WRECV) || (s == ST_BUSY);
    endfunction

    function automatic logic byte_phase(input seq_state_e s);
        return (s == ST_WRECV) || (s == ST_RECV) || (s == ST_WSEND) || (s == ST_SEND);
    endfunction

endpackage

// File: rtl/sdseq_byte_cnt.sv
module sdseq_byte_cnt #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic [LEN_W-1:0] count,
    output logic             zero
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec && count != '0) begin
            count <= count - LEN_W'(1);
        end
    end

    assign zero = (count == '0);
endmodule

// File: rtl/sdseq_tmo_cnt.sv
module sdseq_tmo_cnt #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMO_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - TMO_W'(1);
        end
    end

    // a strobe that finds one period left (or none) ends the window
    assign expire = run && (cnt <= TMO_W'(1));
endmodule

// File: rtl/sdseq_fsm.sv
module sdseq_fsm
    import sdseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        card_ce,
    input  logic        start,
    input  logic        dir_send,
    input  logic        byte_stb,
    input  logic        busy_in,
    input  logic        ack_en,
    input  logic        ack_rcvd,
    input  logic        err_in,
    input  logic        cnt_zero,
    input  logic        dtmo_exp,
    input  logic        atmo_exp,
    output logic        cnt_load,
    output logic        cnt_dec,
    output logic        dtmo_load,
    output logic        dtmo_run,
    output logic        atmo_load,
    output logic        atmo_run,
    output seq_state_e  state,
    output seq_events_t events
);
    seq_state_e  nxt;
    seq_events_t ev_nxt;
    logic        err_q;
    logic        clean;

    assign clean     = !(err_q || err_in);
    assign dtmo_run  = card_ce && data_timed(state);
    assign atmo_run  = card_ce && (state == ST_WACK);
    assign cnt_load  = (state == ST_IDLE) && start;
    assign cnt_dec   = byte_stb && !cnt_zero && byte_phase(state);
    assign dtmo_load = data_timed(nxt) && (nxt != state);
    assign atmo_load = (nxt == ST_WACK) && (state != ST_WACK);

    always_comb begin
        nxt    = state;
        ev_nxt = '0;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = dir_send ? ST_WSEND : ST_WRECV;
            end
            ST_WRECV: begin
                if (cnt_zero) begin
                    nxt = ST_IDLE;
                    ev_nxt.data_end = clean;
                end else if (byte_stb) begin
                    nxt = ST_RECV;
                end else if (dtmo_exp) begin
                    nxt = ST_IDLE;
                    ev_nxt.data_tmo = 1'b1;
                end
            end
            ST_RECV: begin
                if (cnt_zero) begin
                    nxt = ST_IDLE;
                    ev_nxt.data_end = clean;
                end
            end
            ST_WSEND: begin
                if (cnt_zero) begin
                    nxt = ST_IDLE;
                    ev_nxt.data_end = clean;
                end else if (byte_stb) begin
                    nxt = ST_SEND;
                end
            end
            ST_SEND: begin
                if (cnt_zero) begin
                    if (busy_in) begin
                        nxt = ST_BUSY;
                    end else if (ack_en) begin
                        nxt = ST_WACK;
                    end else begin
                        nxt = ST_IDLE;
                        ev_nxt.data_end = clean;
                    end
                end
            end
            ST_BUSY: begin
                if (!busy_in) begin
                    if (ack_en) begin
                        nxt = ST_WACK;
                    end else begin
                        nxt = ST_IDLE;
                        ev_nxt.data_end = clean;
                    end
                end else if (dtmo_exp) begin
                    nxt = ST_IDLE;
                    ev_nxt.data_tmo = 1'b1;
                end
            end
            ST_WACK: begin
                if (ack_rcvd) begin
                    nxt = ST_IDLE;
                    ev_nxt.data_end = clean;
                end else if (atmo_exp) begin
                    nxt = ST_IDLE;
                    ev_nxt.ack_tmo = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            events <= '0;
            err_q  <= 1'b0;
        end else begin
            state  <= nxt;
            events <= ev_nxt;
            if (state == ST_IDLE) err_q <= 1'b0;
            else if (err_in)      err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sd_data_seq.sv
module sd_data_seq
    import sdseq_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             card_ce,
    input  logic             start,
    input  logic             dir_send,
    input  logic [LEN_W-1:0] len_in,
    input  logic [TMO_W-1:0] data_tmo_in,
    input  logic [TMO_W-1:0] ack_tmo_in,
    input  logic             byte_stb,
    input  logic             busy_in,
    input  logic             ack_en,
    input  logic             ack_rcvd,
    input  logic             err_in,
    output logic [2:0]       state_o,
    output logic [LEN_W-1:0] remaining_o,
    output logic             data_end_o,
    output logic             data_tmo_o,
    output logic             ack_tmo_o
);
    seq_state_e  state;
    seq_events_t events;
    logic cnt_load, cnt_dec, cnt_zero;
    logic dtmo_load, dtmo_run, dtmo_exp;
    logic atmo_load, atmo_run, atmo_exp;

    sdseq_fsm u_fsm (
        .clk(clk), .rst(rst), .card_ce(card_ce), .start(start),
        .dir_send(dir_send), .byte_stb(byte_stb), .busy_in(busy_in),
        .ack_en(ack_en), .ack_rcvd(ack_rcvd), .err_in(err_in),
        .cnt_zero(cnt_zero), .dtmo_exp(dtmo_exp), .atmo_exp(atmo_exp),
        .cnt_load(cnt_load), .cnt_dec(cnt_dec),
        .dtmo_load(dtmo_load), .dtmo_run(dtmo_run),
        .atmo_load(atmo_load), .atmo_run(atmo_run),
        .state(state), .events(events)
    );

    sdseq_byte_cnt #(.LEN_W(LEN_W)) u_bytes (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(len_in),
        .dec(cnt_dec), .count(remaining_o), .zero(cnt_zero)
    );

    sdseq_tmo_cnt #(.TMO_W(TMO_W)) u_data_tmr (
        .clk(clk), .rst(rst), .load(dtmo_load), .load_val(data_tmo_in),
        .run(dtmo_run), .expire(dtmo_exp)
    );

    sdseq_tmo_cnt #(.TMO_W(TMO_W)) u_ack_tmr (
        .clk(clk), .rst(rst), .load(atmo_load), .load_val(ack_tmo_in),
        .run(atmo_run), .expire(atmo_exp)
    );

    assign state_o    = state;
    assign data_end_o = events.data_end;
    assign data_tmo_o = events.data_tmo;
    assign ack_tmo_o  = events.ack_tmo;
endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk
    import sdseq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [LEN_W-1:0] len_in,
    input logic             ack_rcvd,
    input logic             err_in,
    input logic [2:0]       state_o,
    input logic [LEN_W-1:0] remaining_o,
    input logic             data_end_o,
    input logic             data_tmo_o,
    input logic             ack_tmo_o
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE && start) |=> ((state_o == ST_WRECV || state_o == ST_WSEND) && remaining_o == $past(len_in))); // R1
    AST_REM_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (seen && state_o != ST_IDLE && $past(state_o) != ST_IDLE) |-> (remaining_o <= $past(remaining_o))); // R2
    AST_EVENT_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (data_end_o || data_tmo_o || ack_tmo_o) |-> (state_o == ST_IDLE)); // R3
    AST_DTMO_PHASE: assert property (@(posedge clk) disable iff (rst)
        data_tmo_o |-> (seen && ($past(state_o) == ST_WRECV || $past(state_o) == ST_BUSY))); // R5
    AST_ATMO_PHASE: assert property (@(posedge clk) disable iff (rst)
        ack_tmo_o |-> (seen && $past(state_o) == ST_WACK)); // R6
    AST_ACK_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_WACK && ack_rcvd) |=> (state_o == ST_IDLE && !ack_tmo_o)); // R8
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE && start && len_in == '0) ##1 !err_in |=> (state_o == ST_IDLE && data_end_o)); // R9
    AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({data_end_o, data_tmo_o, ack_tmo_o})); // R11
    AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (data_end_o || data_tmo_o || ack_tmo_o) |=> !(data_end_o || data_tmo_o || ack_tmo_o)); // R11
endmodule

bind sd_data_seq sdseq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .len_in(len_in),
    .ack_rcvd(ack_rcvd), .err_in(err_in), .state_o(state_o),
    .remaining_o(remaining_o), .data_end_o(data_end_o),
    .data_tmo_o(data_tmo_o), .ack_tmo_o(ack_tmo_o)
);

// File: tb/tb_sd_data_seq.sv
module tb_sd_data_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int TMO_W = 16;
    localparam int WATCHDOG = 150000;
    localparam int BIG_TMO = 16'hFFFF;

    logic clk = 1'b0;
    logic rst;
    logic card_ce, start, dir_send, byte_stb, busy_in, ack_en, ack_rcvd, err_in;
    logic [LEN_W-1:0] len_in;
    logic [TMO_W-1:0] data_tmo_in, ack_tmo_in;
    logic [2:0] state_o;
    logic [LEN_W-1:0] remaining_o;
    logic data_end_o, data_tmo_o, ack_tmo_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_data_seq #(.LEN_W(LEN_W), .TMO_W(TMO_W)) dut (
        .clk(clk), .rst(rst), .card_ce(card_ce), .start(start), .dir_send(dir_send),
        .len_in(len_in), .data_tmo_in(data_tmo_in), .ack_tmo_in(ack_tmo_in),
        .byte_stb(byte_stb), .busy_in(busy_in), .ack_en(ack_en), .ack_rcvd(ack_rcvd),
        .err_in(err_in), .state_o(state_o), .remaining_o(remaining_o),
        .data_end_o(data_end_o), .data_tmo_o(data_tmo_o), .ack_tmo_o(ack_tmo_o)
    );

    function automatic int strobes_to_expire(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic int end_expected(input bit had_err);
        return had_err ? 0 : 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet();
        card_ce = 0; start = 0; byte_stb = 0; ack_rcvd = 0; err_in = 0;
    endtask

    task automatic begin_xfer(input bit dir, input int len, input int dt, input int at);
        start = 1; dir_send = dir; len_in = LEN_W'(len);
        data_tmo_in = TMO_W'(dt); ack_tmo_in = TMO_W'(at);
        step();
        start = 0;
        chk("R1 state", int'(state_o), dir ? 1 : 5);
        chk("R1 remaining", int'(remaining_o), len);
    endtask

    // receive with random gaps; err_idx < 0 means no error
    task automatic run_rx(input int len, input int err_idx);
        int rem = len;
        int st = 5;
        begin_xfer(1'b0, len, BIG_TMO, BIG_TMO);
        if (len == 0) begin
            step();
            chk("R9 rx idle", int'(state_o), 0);
            chk("R9 rx data_end", int'(data_end_o), 1);
            step();
            chk("R11 width", int'(data_end_o), 0);
            return;
        end
        for (int i = 0; i < len; i++) begin
            for (int g = 0; g < int'($urandom_range(0, 2)); g++) begin
                card_ce = 1'($urandom);
                step();
                chk("R2 hold remaining", int'(remaining_o), rem);
                chk("R2 hold state", int'(state_o), st);
            end
            byte_stb = 1; card_ce = 1'($urandom); err_in = (i == err_idx);
            step();
            quiet();
            rem--; st = 6;
            chk("R2 remaining", int'(remaining_o), rem);
            chk("R2 state", int'(state_o), 6);
        end
        step();
        chk("R3 idle", int'(state_o), 0);
        chk(err_idx >= 0 ? "R4 data_end" : "R3 data_end", int'(data_end_o), end_expected(err_idx >= 0));
        chk("R11 tmo quiet", int'(data_tmo_o | ack_tmo_o), 0);
        step();
        chk("R11 width", int'(data_end_o), 0);
    endtask

    // send; busy_n cycles of busy, ack_wait < 0 means no ack expected
    task automatic run_tx(input int len, input int busy_n, input int ack_wait, input bit err);
        int rem = len;
        begin_xfer(1'b1, len, BIG_TMO, BIG_TMO);
        busy_in = (busy_n > 0); ack_en = (ack_wait >= 0);
        for (int i = 0; i < len; i++) begin
            byte_stb = 1; card_ce = 1'($urandom); err_in = err && (i == 0);
            step();
            quiet();
            rem--;
            chk("R2 tx remaining", int'(remaining_o), rem);
            chk("R2 tx state", int'(state_o), 2);
        end
        step();
        if (busy_n > 0) begin
            chk("R7 busy entry", int'(state_o), 3);
            for (int b = 1; b < busy_n; b++) begin
                card_ce = 1'($urandom);
                step();
                chk("R7 busy hold", int'(state_o), 3);
            end
            busy_in = 0;
            step();
        end
        if (ack_wait >= 0) begin
            chk("R7 ack entry", int'(state_o), 4);
            for (int a = 0; a < ack_wait; a++) begin
                card_ce = 1'($urandom);
                step();
                chk("R8 ack hold", int'(state_o), 4);
            end
            ack_rcvd = 1;
            step();
            ack_rcvd = 0;
            chk("R8 idle", int'(state_o), 0);
            chk("R8 data_end", int'(data_end_o), end_expected(err));
        end else begin
            chk("R7 idle", int'(state_o), 0);
            chk(err ? "R4 tx data_end" : "R7 data_end", int'(data_end_o), end_expected(err));
        end
        quiet(); busy_in = 0; ack_en = 0;
        step();
        chk("R11 tx width", int'(data_end_o), 0);
    endtask

    // count strobes in a supervised phase until expiry
    task automatic count_out(input int t, input int phase, input string req, input bit ack_side);
        int need = strobes_to_expire(t);
        int seen = 0;
        for (int i = 0; i < 400; i++) begin
            card_ce = ((i % 4) == 3) ? 1'b1 : 1'($urandom);
            if (card_ce) seen++;
            step();
            card_ce = 0;
            if (seen == need) begin
                chk({req, " idle"}, int'(state_o), 0);
                chk({req, " event"}, int'(ack_side ? ack_tmo_o : data_tmo_o), 1);
                chk("R11 no data_end", int'(data_end_o), 0);
                break;
            end
            chk({req, " still waiting"}, int'(state_o), phase);
        end
        step();
        chk("R11 tmo width", int'(data_tmo_o | ack_tmo_o), 0);
    endtask

    task automatic dtmo_rx(input int t);
        begin_xfer(1'b0, 5, t, BIG_TMO);
        count_out(t, 5, "R5 rx", 1'b0);
    endtask

    task automatic dtmo_busy(input int t);
        begin_xfer(1'b1, 1, t, BIG_TMO);
        busy_in = 1; ack_en = 0;
        byte_stb = 1; card_ce = 1;
        step();
        byte_stb = 0; card_ce = 1;
        step();
        chk("R7 busy reached", int'(state_o), 3);
        count_out(t, 3, "R5 busy", 1'b0);
        busy_in = 0;
    endtask

    task automatic atmo(input int t);
        begin_xfer(1'b1, 1, BIG_TMO, t);
        busy_in = 0; ack_en = 1;
        byte_stb = 1; card_ce = 1;
        step();
        byte_stb = 0; card_ce = 1;
        step();
        chk("R7 ack reached", int'(state_o), 4);
        count_out(t, 4, "R6 ack", 1'b1);
        ack_en = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        quiet(); dir_send = 0; busy_in = 0; ack_en = 0;
        len_in = '0; data_tmo_in = '0; ack_tmo_in = '0;
        rst = 1;
        repeat (3) step();
        rst = 0;
        step();
        chk("R12 state", int'(state_o), 0);
        chk("R12 remaining", int'(remaining_o), 0);
        chk("R12 events", int'({data_end_o, data_tmo_o, ack_tmo_o}), 0);

        // directed corners
        run_rx(0, -1);
        begin_xfer(1'b1, 0, BIG_TMO, BIG_TMO);
        step();
        chk("R9 tx idle", int'(state_o), 0);
        chk("R9 tx data_end", int'(data_end_o), 1);
        step();
        run_rx(1, -1);
        run_rx(3, 1);
        run_tx(2, 0, -1, 1'b0);
        run_tx(2, 3, 2, 1'b0);
        run_tx(1, 2, -1, 1'b1);

        // R10: start while busy with a transfer
        begin_xfer(1'b0, 4, BIG_TMO, BIG_TMO);
        start = 1; dir_send = 1; len_in = 16'd9;
        step();
        chk("R10 state", int'(state_o), 5);
        chk("R10 remaining", int'(remaining_o), 4);
        byte_stb = 1;
        step();
        chk("R10 recv remaining", int'(remaining_o), 3);
        chk("R10 recv state", int'(state_o), 6);
        quiet();
        for (int i = 0; i < 3; i++) begin byte_stb = 1; step(); end
        quiet();
        step();
        chk("R3 after ignored start", int'(data_end_o), 1);
        step();

        // timeouts: zero, one, then back-to-back reloads
        dtmo_rx(0);
        dtmo_rx(1);
        dtmo_rx(3);
        dtmo_rx(3);
        dtmo_busy(0);
        dtmo_busy(4);
        atmo(0);
        atmo(5);
        atmo(2);

        // constrained random mix
        for (int n = 0; n < 60; n++) begin
            case ($urandom_range(0, 4))
                0: run_rx($urandom_range(0, 12), ($urandom_range(0, 3) == 0) ? 0 : -1);
                1: run_tx($urandom_range(1, 10), $urandom_range(0, 3),
                          ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 3)) : -1,
                          $urandom_range(0, 4) == 0);
                2: dtmo_rx($urandom_range(0, 8));
                3: dtmo_busy($urandom_range(0, 8));
                default: atmo($urandom_range(0, 8));
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule